// File: doc/BRIEF.md
# Multi-rail power sequencing controller

This block switches on up to three supply rails in a fixed order and then watches over them. It does no analog work. Its inputs are registered comparator flags: an enable flag with separate rising and falling thresholds, a set flag per channel, a supply-present flag per channel, and two flags per output. One output flag shows that the output has reached its power-good fraction. The other shows that the output is below a low discharge level. The block drives a gate enable per channel, a discharge pulldown per channel, a ramp direction command, a fault flag and a power-good/reset line.

When enable is high and every set flag is high, the controller brings up each present channel in ascending order. Before each channel it waits a delay interval. It then waits for that output to reach power-good before the next channel's delay starts. After the last channel, a power-good timeout runs, and then the power-good/reset line goes high. A single fault window covers the whole ramp phase. A timeout, the loss of a set flag while ramping, or the loss of power-good on a gated rail aborts the sequence. Power-down starts when enable drops below its falling threshold, and all rails ramp down together. After a fault, a parameter selects one of two behaviours. In autoretry, the controller waits a retry interval, then a delay, and then re-qualifies the start conditions. In latch-off, the fault holds until enable is removed.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset every output is low: gate_en_o, pulldown_o, ramp_up_o, fault_o and pg_o.
- R2: A sequence starts only while en_on_i is high, every set_ok_i bit is high, and at least one in_present_i bit is high. The first gate enable rises DELAY_CYC+1 cycles after the cycle in which these conditions are first sampled true.
- R3: Channels are gated strictly in ascending index order, at most one new gate per cycle. The next channel's gate rises DELAY_CYC+1 cycles after the previous channel's out_pg_i bit is sampled high.
- R4: A channel with in_present_i low is excluded. Its gate never rises, and no delay interval is spent on it.
- R5: pg_o rises PG_CYC+1 cycles after the out_pg_i bit of the last active channel is sampled high. While pg_o is high, ramp_up_o is high and fault_o is low.
- R6: If the ramp phase has not completed FAULT_CYC cycles after it started, the next cycle shows every gate low and fault_o high.
- R7: A low set_ok_i bit during the ramp phase, or a low out_pg_i bit on a gated channel after the ramp phase, raises fault_o in the next cycle. In that same cycle all gates and pg_o go low.
- R8: After en_off_i is sampled high, pg_o and ramp_up_o are low in the next cycle while the gates stay unchanged. The gates are released together, in the cycle after every active out_low_i bit is high.
- R9: With AUTORETRY=1, a fault holds every gate off and every pulldown on for RETRY_CYC cycles. A further DELAY_CYC-cycle wait follows. A restart takes place only when the start conditions hold and every active out_low_i bit is high. fault_o and the pulldowns clear in the cycle after the restart.
- R10: With AUTORETRY=0, fault_o and the pulldowns hold until en_off_i is sampled high. They clear in the next cycle. A new sequence then needs en_on_i again.
- R11: A pulldown is never enabled in a cycle in which any gate is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_on_i | input | 1 | Enable above rising threshold |
| en_off_i | input | 1 | Enable below falling threshold |
| set_ok_i | input | NCH | Per-channel set input above threshold |
| in_present_i | input | NCH | Per-channel supply input present |
| out_pg_i | input | NCH | Output above power-good fraction |
| out_low_i | input | NCH | Output below discharge level |
| gate_en_o | output | NCH | Per-channel pass gate enable |
| pulldown_o | output | NCH | Per-channel discharge pulldown |
| ramp_up_o | output | 1 | Reference ramp direction: 1 up, 0 down |
| fault_o | output | 1 | Fault flag |
| pg_o | output | 1 | Power-good / reset release |

## Verification
The sequence is first run with every channel present. Exact-cycle checks on each gate edge separate a correct per-channel delay from an off-by-one or a skipped delay. A run with the middle channel absent shows whether the controller skips it without spending a delay on it. A run in which no output ever reaches power-good isolates the global fault window. Separate runs drop a set flag in mid-ramp, or drop power-good after completion, to test the abort paths. After a fault, output-low flags held high must block the autoretry restart. A second instance built for latch-off is given the same stimulus, so the two fault policies can be compared cycle for cycle.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RAMP,
    ST_PGWAIT,
    ST_ON,
    ST_DOWN,
    ST_RETRY,
    ST_RQUAL,
    ST_LATCH
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         run_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= len_i - W'(1);
    else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rail_seq_pick.sv
// Selects the lowest present channel above cur_i, or the lowest overall when first_i.
module rail_seq_pick #(
  parameter int NCH = 3,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] act_i,
  input  logic [CW-1:0]  cur_i,
  input  logic           first_i,
  output logic [CW-1:0]  nxt_o,
  output logic           has_o
);
  always_comb begin
    nxt_o = '0;
    has_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (act_i[i] && (first_i || CW'(i) > cur_i)) begin
        nxt_o = CW'(i);
        has_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rail_seq_qual.sv
module rail_seq_qual #(
  parameter int NCH = 3
) (
  input  logic           en_on_i,
  input  logic [NCH-1:0] set_ok_i,
  input  logic [NCH-1:0] present_i,
  input  logic [NCH-1:0] out_pg_i,
  input  logic [NCH-1:0] out_low_i,
  input  logic [NCH-1:0] gate_i,
  output logic           sets_ok_o,
  output logic           start_ok_o,
  output logic           all_low_o,
  output logic           retry_ok_o,
  output logic           pg_lost_o
);
  assign sets_ok_o  = &set_ok_i;
  assign start_ok_o = en_on_i && sets_ok_o && (|present_i);
  assign all_low_o  = &(out_low_i | ~present_i);
  assign retry_ok_o = start_ok_o && all_low_o;
  assign pg_lost_o  = |(gate_i & ~out_pg_i);
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int DELAY_CYC = 8,
  parameter int FAULT_CYC = 60,
  parameter int PG_CYC    = 6,
  parameter int RETRY_CYC = 20,
  parameter bit AUTORETRY = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_on_i,
  input  logic           en_off_i,
  input  logic [NCH-1:0] set_ok_i,
  input  logic [NCH-1:0] in_present_i,
  input  logic [NCH-1:0] out_pg_i,
  input  logic [NCH-1:0] out_low_i,
  output logic [NCH-1:0] gate_en_o,
  output logic [NCH-1:0] pulldown_o,
  output logic           ramp_up_o,
  output logic           fault_o,
  output logic           pg_o
);
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TMAX = imax(imax(DELAY_CYC, FAULT_CYC), imax(PG_CYC, RETRY_CYC));
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_e     state_q, state_d;
  logic [CW-1:0]  cur_q, cur_d;
  logic [NCH-1:0] mask_q, mask_d;

  logic           ld_step, ld_flt, step_done, flt_done, in_ramp;
  logic [TW-1:0]  step_len;
  logic [CW-1:0]  nxt;
  logic           has_nxt, pick_first;
  logic           sets_ok, start_ok, all_low, retry_ok, pg_lost;

  assign in_ramp    = (state_q == ST_DELAY) || (state_q == ST_RAMP);
  assign pick_first = (state_q == ST_IDLE) || (state_q == ST_RQUAL);

  rail_seq_timer #(.W(TW)) u_step (
    .clk_i, .rst_ni, .load_i(ld_step), .len_i(step_len), .run_i(1'b1), .done_o(step_done)
  );

  rail_seq_timer #(.W(TW)) u_flt (
    .clk_i, .rst_ni, .load_i(ld_flt), .len_i(TW'(FAULT_CYC)), .run_i(in_ramp), .done_o(flt_done)
  );

  rail_seq_pick #(.NCH(NCH)) u_pick (
    .act_i(in_present_i), .cur_i(cur_q), .first_i(pick_first), .nxt_o(nxt), .has_o(has_nxt)
  );

  rail_seq_qual #(.NCH(NCH)) u_qual (
    .en_on_i, .set_ok_i, .present_i(in_present_i), .out_pg_i, .out_low_i, .gate_i(mask_q),
    .sets_ok_o(sets_ok), .start_ok_o(start_ok), .all_low_o(all_low),
    .retry_ok_o(retry_ok), .pg_lost_o(pg_lost)
  );

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    mask_d   = mask_q;
    ld_step  = 1'b0;
    ld_flt   = 1'b0;
    step_len = TW'(DELAY_CYC);
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_DELAY;
          cur_d   = nxt;
          ld_step = 1'b1;
          ld_flt  = 1'b1;
        end
      end
      ST_DELAY, ST_RAMP: begin
        if (en_off_i) begin
          state_d = ST_DOWN;
        end else if (flt_done || !sets_ok) begin
          mask_d  = '0;
          state_d = AUTORETRY ? ST_RETRY : ST_LATCH;
          ld_step = 1'b1;
          step_len = TW'(RETRY_CYC);
        end else if (state_q == ST_DELAY) begin
          if (step_done) begin
            state_d       = ST_RAMP;
            mask_d[cur_q] = 1'b1;
          end
        end else if (out_pg_i[cur_q]) begin
          ld_step = 1'b1;
          if (has_nxt) begin
            state_d = ST_DELAY;
            cur_d   = nxt;
          end else begin
            state_d  = ST_PGWAIT;
            step_len = TW'(PG_CYC);
          end
        end
      end
      ST_PGWAIT, ST_ON: begin
        if (en_off_i) begin
          state_d = ST_DOWN;
        end else if (pg_lost) begin
          mask_d   = '0;
          state_d  = AUTORETRY ? ST_RETRY : ST_LATCH;
          ld_step  = 1'b1;
          step_len = TW'(RETRY_CYC);
        end else if (state_q == ST_PGWAIT && step_done) begin
          state_d = ST_ON;
        end
      end
      ST_DOWN: begin
        if (all_low) begin
          state_d = ST_IDLE;
          mask_d  = '0;
        end
      end
      ST_RETRY: begin
        if (step_done) begin
          state_d = ST_RQUAL;
          ld_step = 1'b1;
        end
      end
      ST_RQUAL: begin
        if (step_done && retry_ok) begin
          state_d = ST_DELAY;
          cur_d   = nxt;
          ld_step = 1'b1;
          ld_flt  = 1'b1;
        end
      end
      ST_LATCH: begin
        if (en_off_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      mask_q  <= mask_d;
    end
  end

  logic faulted;
  assign faulted    = (state_q == ST_RETRY) || (state_q == ST_RQUAL) || (state_q == ST_LATCH);
  assign gate_en_o  = mask_q;
  assign pulldown_o = {NCH{faulted}};
  assign fault_o    = faulted;
  assign pg_o       = (state_q == ST_ON);
  assign ramp_up_o  = in_ramp || (state_q == ST_PGWAIT) || (state_q == ST_ON);
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] in_present_i,
  input logic [NCH-1:0] gate_en_o,
  input logic [NCH-1:0] pulldown_o,
  input logic           ramp_up_o,
  input logic           fault_o,
  input logic           pg_o
);
  assert_one_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_en_o & ~$past(gate_en_o)) <= 1);

  assert_excluded_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_o & ~in_present_i) == '0);

  assert_pg_ramp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_o |-> (ramp_up_o && !fault_o));

  assert_fault_gates_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (gate_en_o == '0 && !pg_o));

  assert_fall_together_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(gate_en_o) & ~gate_en_o)) |-> (gate_en_o == '0));

  assert_pd_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulldown_o) |-> (gate_en_o == '0));
endmodule

bind rail_seq_ctrl rail_seq_chk #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_present_i(in_present_i), .gate_en_o(gate_en_o),
  .pulldown_o(pulldown_o), .ramp_up_o(ramp_up_o), .fault_o(fault_o), .pg_o(pg_o)
);

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
  localparam int NCH = 3, D = 8, F = 60, PGC = 6, R = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_on = 1'b0, en_off = 1'b1;
  logic [NCH-1:0] set_ok = '1, present = '1, out_pg = '0, out_low = '1;
  logic [NCH-1:0] gate, pd, gate_l, pd_l;
  logic ramp, fault, pg, ramp_l, fault_l, pg_l;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rail_seq_ctrl #(.NCH(NCH), .DELAY_CYC(D), .FAULT_CYC(F), .PG_CYC(PGC), .RETRY_CYC(R),
                  .AUTORETRY(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_on_i(en_on), .en_off_i(en_off), .set_ok_i(set_ok),
    .in_present_i(present), .out_pg_i(out_pg), .out_low_i(out_low), .gate_en_o(gate),
    .pulldown_o(pd), .ramp_up_o(ramp), .fault_o(fault), .pg_o(pg));

  rail_seq_ctrl #(.NCH(NCH), .DELAY_CYC(D), .FAULT_CYC(F), .PG_CYC(PGC), .RETRY_CYC(R),
                  .AUTORETRY(1'b0)) u_dut_latch (
    .clk_i(clk), .rst_ni(rst_n), .en_on_i(en_on), .en_off_i(en_off), .set_ok_i(set_ok),
    .in_present_i(present), .out_pg_i(out_pg), .out_low_i(out_low), .gate_en_o(gate_l),
    .pulldown_o(pd_l), .ramp_up_o(ramp_l), .fault_o(fault_l), .pg_o(pg_l));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seq_to_on(input string tag);
    int n = 0;
    while (!pg && n < 600) begin
      @(negedge clk);
      n++;
      for (int k = 0; k < NCH; k++)
        if (gate[k] && !out_pg[k]) begin out_pg[k] = 1'b1; out_low[k] = 1'b0; end
    end
    chk(tag, pg, 1);
  endtask

  task automatic go_idle();
    en_on = 1'b0; en_off = 1'b1; out_pg = '0; out_low = '1;
    negs(4);
    chk("R8 idle gates off", gate, 0);
  endtask

  task automatic t_reset();
    negs(3);
    chk("R1 gate", gate, 0); chk("R1 pulldown", pd, 0); chk("R1 ramp", ramp, 0);
    chk("R1 fault", fault, 0); chk("R1 pg", pg, 0);
    rst_n = 1'b1;
    negs(2);
  endtask

  task automatic t_normal();
    set_ok = 3'b101; en_off = 1'b0; en_on = 1'b1;
    negs(3 * D);
    chk("R2 no start with set low", {ramp, gate}, 0);
    set_ok = 3'b111;
    negs(D);
    chk("R2 gate0 before delay", gate, 3'b000);
    negs(1);
    chk("R2 gate0 after delay", gate, 3'b001);
    out_pg[0] = 1'b1; out_low[0] = 1'b0;
    negs(D);
    chk("R3 gate1 before delay", gate, 3'b001);
    negs(1);
    chk("R3 gate1 in order", gate, 3'b011);
    out_pg[1] = 1'b1; out_low[1] = 1'b0;
    negs(D + 1);
    chk("R3 gate2 in order", gate, 3'b111);
    out_pg[2] = 1'b1; out_low[2] = 1'b0;
    negs(PGC);
    chk("R5 pg before timeout", pg, 0);
    negs(1);
    chk("R5 pg after timeout", pg, 1);
    chk("R5 fault low", fault, 0);
    // power-down
    en_on = 1'b0; en_off = 1'b1;
    negs(1);
    chk("R8 pg drops", pg, 0); chk("R8 ramp down", ramp, 0); chk("R8 gates held", gate, 3'b111);
    out_pg = '0; out_low = 3'b011;
    negs(2);
    chk("R8 gates held until all low", gate, 3'b111);
    out_low = 3'b111;
    negs(1);
    chk("R8 gates released together", gate, 3'b000);
    chk("R8 no pulldown", pd, 0);
  endtask

  task automatic t_exclude();
    bit seen1 = 1'b0;
    present = 3'b101;
    en_off = 1'b0; en_on = 1'b1;
    negs(D + 1);
    chk("R4 gate0", gate, 3'b001);
    out_pg[0] = 1'b1; out_low[0] = 1'b0;
    for (int i = 0; i < D + 1; i++) begin negs(1); if (gate[1]) seen1 = 1'b1; end
    chk("R4 skip absent channel", gate, 3'b101);
    out_pg[2] = 1'b1; out_low[2] = 1'b0;
    for (int i = 0; i < PGC + 1; i++) begin negs(1); if (gate[1]) seen1 = 1'b1; end
    chk("R4 pg without excluded", pg, 1);
    chk("R4 excluded never gated", seen1, 0);
    go_idle();
    present = 3'b111;
  endtask

  task automatic t_timeout();
    bit bad_hold = 1'b0;
    en_off = 1'b0; en_on = 1'b1;
    negs(F);
    chk("R6 no fault before window", {fault, gate}, {1'b0, 3'b001});
    negs(1);
    chk("R6 fault flagged", fault, 1);
    chk("R6 gates off", gate, 0);
    chk("R11 pulldowns on", pd, 3'b111);
    chk("R10 latch fault", fault_l, 1);
    out_low = 3'b110;
    for (int i = 0; i < R + 2 * D + 4; i++) begin
      negs(1);
      if (gate != 0 || pd != 3'b111 || !fault) bad_hold = 1'b1;
    end
    chk("R9 held off while output high", bad_hold, 0);
    chk("R10 latch holds", {fault_l, pd_l}, {1'b1, 3'b111});
    out_low = 3'b111;
    negs(1);
    chk("R9 restart clears fault", {fault, pd}, 0);
    negs(D);
    chk("R9 retry gate0", gate, 3'b001);
    chk("R10 latch still faulted", fault_l, 1);
    seq_to_on("R9 retry completes");
    en_on = 1'b0; en_off = 1'b1;
    negs(1);
    chk("R10 latch clears on enable low", {fault_l, pd_l}, 0);
    go_idle();
  endtask

  task automatic t_abort();
    en_off = 1'b0; en_on = 1'b1;
    negs(D + 1);
    chk("R2 gate0 again", gate, 3'b001);
    chk("R10 latch restarts", gate_l, 3'b001);
    out_pg[0] = 1'b1; out_low[0] = 1'b0;
    negs(D + 2);
    chk("R3 gate1 ramping", gate, 3'b011);
    set_ok[2] = 1'b0;
    negs(1);
    chk("R7 set drop aborts", {fault, gate}, {1'b1, 3'b000});
    set_ok = '1; out_pg = '0; out_low = '1;
    seq_to_on("R9 recovers after abort");
    go_idle();
  endtask

  task automatic t_pglost();
    en_off = 1'b0; en_on = 1'b1;
    seq_to_on("R5 reach on");
    out_pg[1] = 1'b0;
    negs(1);
    chk("R7 pg loss faults", {fault, pg, gate}, {1'b1, 1'b0, 3'b000});
    out_pg = '0; out_low = '1;
    seq_to_on("R9 recovers after pg loss");
    go_idle();
  endtask

  initial begin
    t_reset();
    t_normal();
    t_exclude();
    t_timeout();
    t_abort();
    t_pglost();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule